// File: doc/BRIEF.md
# Feature Status Mailbox Responder

This block is the device side of a small memory-mapped mailbox through which host software asks whether a power-management feature is enabled and whether its settings are locked against writes. The host sees two 64-bit registers: a control/status word and a command word. The upper half of the command word doubles as the data dword. Before it can start a request, the host must hold the mailbox. Writing a command word while nobody holds it makes the in-band host the owner.

The host starts the request by setting the run-busy bit together with a packet length. The block keeps run-busy raised for a fixed, parameterised number of cycles. It then decodes the command and looks up the requested feature in a parameter table. It writes a completion code into the status field and a result into the data dword. The host reads the result and writes the completion bit, which releases the mailbox so that the next requester can claim it.

Only the get-state command is understood. Any other command, a wrong packet length or a feature number beyond the table completes with an error code and a zero result.

Top module: `fstat_mailbox`

## Requirements
- R1: After reset the control/status word (offset 0x00) and the command word (offset 0x08) both read as zero.
- R2: A write to offset 0x08 while run-busy is clear stores all 64 bits, and they read back unchanged. If the owner field (control bits 5:4) was 0 (none), it becomes 1 (in-band host).
- R3: A control write with bit 0 set starts a request only when the owner field is 1 and run-busy is clear. Otherwise run-busy stays 0 and the control word is unchanged.
- R4: Once a request starts, reads sampled at the 1st to the BUSY_CYC-th clock edge after the starting write show bit 0 as 1, and the next read shows it as 0.
- R5: Command byte 0x10 (command word bits 7:0), packet length 2 (control bits 23:16) and a feature number (command bits 47:40) below NUM_FEAT complete with status 0x40 in control bits 15:8. The data dword then holds the feature's enable flag in bit 0 and its lock flag in bit 31, with all other bits 0. Bits 31:0 of the command word are kept.
- R6: Any command byte other than 0x10, with a correct length, completes with status 0x81 and a zero data dword.
- R7: A valid get-state request naming a feature number of NUM_FEAT or above completes with status 0x83 and a zero data dword.
- R8: A packet length other than 2 completes with status 0x82 and a zero data dword. Error priority is length first, then command byte, then feature number.
- R9: A control write with bit 6 set and bit 0 clear, while the owner is 1 and run-busy is clear, sets the owner to 0 and clears the status and length fields. While run-busy is set it has no effect.
- R10: Writes to the command word while run-busy is set are ignored.
- R11: Read data appears one cycle after the read strobe. Offset 0x0C returns the data dword in bits 31:0, and every other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |

## Verification
The bench sweeps the feature number over every table entry and past the end. Against table masks with mixed bits, this shows that enable and lock are read from the correct entry and land in the correct bit positions. Several unknown command bytes, bad packet lengths and combined faults check each error code and the order in which faults are ranked. Ordering patterns are also driven: a start without ownership, command and completion writes landing inside the busy window, and back-to-back status reads after a start. These separate a design that holds and releases the mailbox correctly, with the exact busy length, from one that accepts writes at the wrong moment.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int WORD_W  = 64;
  localparam int DWORD_W = 32;
  localparam int BYTE_W  = 8;

  // control/status field positions
  localparam int CS_RUN_BIT  = 0;
  localparam int CS_DONE_BIT = 6;
  localparam int CS_LEN_LO   = 16;
  // command word field positions
  localparam int CMD_FID_LO  = 40;
  localparam int CMD_DAT_LO  = 32;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1
  } owner_t;

  localparam logic [BYTE_W-1:0] OP_GET_STATE = 8'h10;
  localparam logic [BYTE_W-1:0] PKT_LEN_OK   = 8'd2;
  localparam logic [BYTE_W-1:0] ST_OK        = 8'h40;
  localparam logic [BYTE_W-1:0] ST_BAD_OP    = 8'h81;
  localparam logic [BYTE_W-1:0] ST_BAD_LEN   = 8'h82;
  localparam logic [BYTE_W-1:0] ST_BAD_FEAT  = 8'h83;
endpackage

// File: rtl/fstat_lookup.sv
module fstat_lookup
  import fstat_pkg::*;
#(
  parameter int                  NUM_FEAT = 8,
  parameter logic [NUM_FEAT-1:0] FEAT_EN  = '1,
  parameter logic [NUM_FEAT-1:0] FEAT_LCK = '0
) (
  input  logic [BYTE_W-1:0]  op_code,
  input  logic [BYTE_W-1:0]  feat_id,
  input  logic [BYTE_W-1:0]  pkt_len,
  output logic [BYTE_W-1:0]  code,
  output logic [DWORD_W-1:0] result
);
  logic hit, en_bit, lk_bit;

  always_comb begin
    hit    = 1'b0;
    en_bit = 1'b0;
    lk_bit = 1'b0;
    for (int i = 0; i < NUM_FEAT; i++) begin
      if (feat_id == BYTE_W'(i)) begin
        hit    = 1'b1;
        en_bit = FEAT_EN[i];
        lk_bit = FEAT_LCK[i];
      end
    end
  end

  always_comb begin
    result = '0;
    if (pkt_len != PKT_LEN_OK) begin
      code = ST_BAD_LEN;
    end else if (op_code != OP_GET_STATE) begin
      code = ST_BAD_OP;
    end else if (!hit) begin
      code = ST_BAD_FEAT;
    end else begin
      code = ST_OK;
      result[0]         = en_bit;
      result[DWORD_W-1] = lk_bit;
    end
  end
endmodule

// File: rtl/fstat_seq.sv
module fstat_seq
  import fstat_pkg::*;
#(
  parameter int BUSY_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       claim_req,
  input  logic       start_req,
  input  logic       done_req,
  output logic [1:0] owner,
  output logic       busy,
  output logic       start_ok,
  output logic       done_ok,
  output logic       finish
);
  localparam int CNT_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC + 1);

  owner_t           own_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_ok = start_req && !busy && (own_q == OWN_HOST);
  assign done_ok  = done_req && !start_req && !busy && (own_q == OWN_HOST);
  assign finish   = busy && (cnt_q == '0);
  assign owner    = own_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= OWN_NONE;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (start_ok) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(BUSY_CYC - 1);
    end else if (done_ok) begin
      own_q <= OWN_NONE;
    end else if (claim_req && own_q == OWN_NONE) begin
      own_q <= OWN_HOST;
    end
  end
endmodule

// File: rtl/fstat_mailbox.sv
module fstat_mailbox
  import fstat_pkg::*;
#(
  parameter int                  ADDR_W   = 4,
  parameter int                  NUM_FEAT = 8,
  parameter logic [NUM_FEAT-1:0] FEAT_EN  = 8'hB5,
  parameter logic [NUM_FEAT-1:0] FEAT_LCK = 8'h3C,
  parameter int                  BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(12);

  logic [WORD_W-1:0]  cmd_q;
  logic [BYTE_W-1:0]  status_q, len_q;
  logic [1:0]         owner_w;
  logic               busy_w, start_ok, done_ok, finish;
  logic [BYTE_W-1:0]  code_w;
  logic [DWORD_W-1:0] result_w;
  logic [WORD_W-1:0]  ctrl_view;

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire cmd_wr  = bus_wr && (bus_addr == A_CMD);

  fstat_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .claim_req(cmd_wr),
    .start_req(ctrl_wr && bus_wdata[CS_RUN_BIT]),
    .done_req (ctrl_wr && bus_wdata[CS_DONE_BIT]),
    .owner    (owner_w),
    .busy     (busy_w),
    .start_ok (start_ok),
    .done_ok  (done_ok),
    .finish   (finish)
  );

  fstat_lookup #(.NUM_FEAT(NUM_FEAT), .FEAT_EN(FEAT_EN), .FEAT_LCK(FEAT_LCK)) u_lookup (
    .op_code(cmd_q[BYTE_W-1:0]),
    .feat_id(cmd_q[CMD_FID_LO +: BYTE_W]),
    .pkt_len(len_q),
    .code   (code_w),
    .result (result_w)
  );

  assign ctrl_view = {40'b0, len_q, status_q, 2'b00, owner_w, 3'b000, busy_w};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      status_q <= '0;
      len_q    <= '0;
    end else begin
      if (cmd_wr && !busy_w) cmd_q <= bus_wdata;
      if (start_ok) begin
        len_q    <= bus_wdata[CS_LEN_LO +: BYTE_W];
        status_q <= '0;
      end
      if (finish) begin
        status_q                       <= code_w;
        cmd_q[CMD_DAT_LO +: DWORD_W]   <= result_w;
      end
      if (done_ok) begin
        status_q <= '0;
        len_q    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_CMD:   bus_rdata <= cmd_q;
        A_DAT:   bus_rdata <= {32'b0, cmd_q[CMD_DAT_LO +: DWORD_W]};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fstat_mailbox_chk.sv
module fstat_mailbox_chk #(
  parameter int ADDR_W   = 4,
  parameter int BUSY_CYC = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_run,
  input logic              wd_done,
  input logic [1:0]        owner,
  input logic              busy,
  input logic [7:0]        status,
  input logic [31:0]       cmd_lo
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  wire ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));
  wire cmd_wr  = bus_wr && (bus_addr == ADDR_W'(8));

  AST_CLAIM_SETS_OWNER: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && !busy && owner == 2'd0 |=> owner == 2'd1); // R2
  AST_START_NEEDS_OWNER: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && wd_run && !busy && owner != 2'd1 |=> !busy); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == BUSY_CYC); // R4
  AST_DONE_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (status == 8'h40 || status == 8'h81 ||
                     status == 8'h82 || status == 8'h83)); // R5
  AST_BUSY_KEEPS_OWNER: assert property (@(posedge clk) disable iff (rst)
    busy |-> owner == 2'd1); // R9
  AST_RELEASE_OWNER: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && wd_done && !wd_run && !busy && owner == 2'd1 |=> owner == 2'd0); // R9
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_lo)); // R10
endmodule

bind fstat_mailbox fstat_mailbox_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .wd_run  (bus_wdata[0]),
  .wd_done (bus_wdata[6]),
  .owner   (owner_w),
  .busy    (busy_w),
  .status  (status_q),
  .cmd_lo  (cmd_q[31:0])
);

// File: tb/test_fstat_mailbox.sv
module test_fstat_mailbox;
  localparam int         NF = 6;
  localparam logic [5:0] EN = 6'b101101;
  localparam logic [5:0] LK = 6'b110010;
  localparam int         BC = 3;
  localparam logic [3:0] A_CTRL = 4'h0, A_CMD = 4'h8, A_DAT = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] rv;

  always #2 clk = ~clk;

  fstat_mailbox #(.ADDR_W(4), .NUM_FEAT(NF), .FEAT_EN(EN), .FEAT_LCK(LK), .BUSY_CYC(BC))
    i_fstat_mailbox (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
                     .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [63:0] ctrl_w(logic b, logic [1:0] o, logic [7:0] s, logic [7:0] l);
    return {40'b0, l, s, 2'b00, o, 3'b000, b};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // full transaction, expected outcome computed from the requirements
  task automatic txn(string tag, logic [7:0] op, logic [7:0] fid, logic [7:0] len);
    logic [63:0] w, r;
    logic [7:0]  es;
    logic [31:0] ed;
    w = 64'(op) | (64'(fid) << 40) | 64'h0000_0000_00A5_5A00;
    wr(A_CMD, w);
    rd(A_CTRL, r); chk({tag, " R2 claim"}, r, ctrl_w(1'b0, 2'd1, 8'h00, 8'h00));
    wr(A_CTRL, 64'h1 | (64'(len) << 16));
    idle(BC + 1);
    ed = '0;
    if (len != 8'd2)         es = 8'h82;
    else if (op != 8'h10)    es = 8'h81;
    else if (fid >= 8'(NF))  es = 8'h83;
    else begin
      es = 8'h40;
      ed = {LK[fid[2:0]], 30'b0, EN[fid[2:0]]};
    end
    rd(A_CTRL, r); chk({tag, " status"}, r, ctrl_w(1'b0, 2'd1, es, len));
    rd(A_CMD, r);  chk({tag, " data"}, r, {ed, w[31:0]});
    rd(A_DAT, r);  chk({tag, " R11 dword"}, r, {32'b0, ed});
    wr(A_CTRL, 64'h40);
    rd(A_CTRL, r); chk({tag, " R9 release"}, r, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 64'h0);
    rd(A_CMD, rv);  chk("R1 cmd", rv, 64'h0);
    // R11 unmapped reads zero
    rd(4'h4, rv); chk("R11 unmapped", rv, 64'h0);
    // R3 start without ownership ignored
    wr(A_CTRL, 64'h0002_0001);
    rd(A_CTRL, rv); chk("R3 no-owner start", rv, 64'h0);
    idle(BC + 1);
    rd(A_CTRL, rv); chk("R3 no-owner later", rv, 64'h0);
    // R2 store and readback, second write while owned
    wr(A_CMD, 64'h1234_5678_9ABC_DEF0);
    rd(A_CMD, rv); chk("R2 store", rv, 64'h1234_5678_9ABC_DEF0);
    wr(A_CMD, 64'h0FED_CBA9_8765_4321);
    rd(A_CMD, rv); chk("R2 overwrite", rv, 64'h0FED_CBA9_8765_4321);
    wr(A_CTRL, 64'h40);
    rd(A_CTRL, rv); chk("R9 release idle", rv, 64'h0);
    // R5 and R7: sweep feature numbers across and beyond the table
    for (int f = 0; f < NF + 3; f++) txn($sformatf("R5/R7 fid=%0d", f), 8'h10, 8'(f), 8'd2);
    txn("R7 fid=255", 8'h10, 8'hFF, 8'd2);
    // R6 unknown command bytes, including bad op with bad feature
    txn("R6 op=00", 8'h00, 8'd0, 8'd2);
    txn("R6 op=11", 8'h11, 8'd1, 8'd2);
    txn("R6 op=FF", 8'hFF, 8'd2, 8'd2);
    txn("R6 op=90 badfid", 8'h90, 8'd9, 8'd2);
    // R8 bad length, length outranks command and feature
    txn("R8 len=0", 8'h10, 8'd0, 8'd0);
    txn("R8 len=1", 8'h10, 8'd2, 8'd1);
    txn("R8 len=3 badop", 8'h22, 8'd3, 8'd3);
    txn("R8 len=FF badfid", 8'h10, 8'd40, 8'hFF);
    // R4 busy window with back-to-back reads
    wr(A_CMD, 64'h0000_0300_0000_0010);
    wr(A_CTRL, 64'h0002_0001);
    for (int k = 1; k <= BC; k++) begin
      rd(A_CTRL, rv); chk($sformatf("R4 busy edge %0d", k), {63'b0, rv[0]}, 64'h1);
    end
    rd(A_CTRL, rv); chk("R4 busy clear", rv, ctrl_w(1'b0, 2'd1, 8'h40, 8'd2));
    wr(A_CTRL, 64'h40);
    // R9/R10: command and completion writes inside the busy window
    wr(A_CMD, 64'h0000_0500_0000_0010);
    wr(A_CTRL, 64'h0002_0001);
    wr(A_CMD, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_CTRL, 64'h40);
    idle(BC + 1);
    rd(A_CTRL, rv); chk("R9 done ignored while busy", rv, ctrl_w(1'b0, 2'd1, 8'h40, 8'd2));
    rd(A_CMD, rv);  chk("R10 cmd ignored while busy", rv,
                        {LK[5], 30'b0, EN[5], 32'h0000_0010});
    // R3 second start while owned but not busy works again, start beats done
    wr(A_CTRL, 64'h0002_0041);
    rd(A_CTRL, rv); chk("R3 restart busy", {63'b0, rv[0]}, 64'h1);
    idle(BC + 1);
    rd(A_CTRL, rv); chk("R3 restart owner kept", rv, ctrl_w(1'b0, 2'd1, 8'h40, 8'd2));
    wr(A_CTRL, 64'h40);
    rd(A_CTRL, rv); chk("R9 final release", rv, 64'h0);
    // writes to the data dword offset change nothing
    wr(A_DAT, 64'hDEAD_BEEF);
    rd(A_CTRL, rv); chk("R11 dword write no owner", rv, 64'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule